// File: doc/BRIEF.md
# Adaptive Page Close Controller

This block sets how often an open-page DRAM controller closes its idle pages. A free-running interval timer raises a one-cycle page-close flag at the end of each interval. The scheduler reports two kinds of outcome. A mistake event means a page was closed too early and then reopened. A hit event means a close was correct. A 12-bit mistake counter starts at mid-scale (2048), moves up on mistakes and down on hits, and is compared against two programmable thresholds each time the flag fires.

The interval is one of eight power-of-two lengths, from 16 to 2048 clocks. It moves at most one step per decision. When the counter is above the upper threshold, the interval halves and closing becomes more aggressive. When the counter is under the lower threshold, the interval doubles. Software supplies only the top 9 bits of each 13-bit threshold, and it sees the counter through its top 8 bits.

All pins are plain control or status levels and pulses. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `page_close_adapt`

## Requirements
- R1: While reset is held and right after it, `close_flag` is 0 and `cnt_msb` reads 0x80. The interval starts at step 3, so the first flag is seen 128 clocks after reset is released.
- R2: `close_flag` is high for exactly one clock. Successive flags are 16<<step clocks apart. The step runs from 0 to 7.
- R3: While `enable` is 1 and no step change occurs, the counter goes up by 1 on a cycle with `mistake` alone and down by 1 on a cycle with `hit` alone. It is unchanged when both are high or neither is high.
- R4: The counter saturates at 4095 and at 0. It never wraps.
- R5: When the flag fires with `enable`=1, the counter zero-extended to 13 bits is compared with `{hi_lim,4'b0000}`. If the counter is strictly greater and the step is above 0, the step drops by one, which halves the interval. The counter is then reloaded to 2048, and any event in that cycle is discarded.
- R6: Under the same conditions, if the counter is strictly less than `{lo_lim,4'b0000}` and the step is below 7, the step rises by one, which doubles the interval. The counter is again reloaded to 2048.
- R7: When the counter is both above the upper threshold and below the lower threshold, the upper comparison wins and the interval shortens.
- R8: At step 0 with the counter over the upper threshold, or at step 7 with it under the lower threshold, the step holds. The counter is not reloaded and keeps counting events.
- R9: While `enable` is 0, both the counter and the step are frozen. The flag keeps firing at the current interval.
- R10: A counter value equal to a threshold triggers no change. The low four bits of each threshold are always zero.
- R11: `cnt_msb` is bits 11 down to 4 of the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Enables adaptation and counting |
| hi_lim | input | 9 | Top 9 bits of the upper 13-bit threshold |
| lo_lim | input | 9 | Top 9 bits of the lower 13-bit threshold |
| mistake | input | 1 | Early-close mistake event, one per high cycle |
| hit | input | 1 | Correct-close event, one per high cycle |
| close_flag | output | 1 | One-cycle page-close pulse |
| cnt_msb | output | 8 | Top 8 bits of the mistake counter |

## Verification
The assertions assume that `mistake` and `hit` are synchronous single-cycle levels that may appear in any cycle, including together or on the firing cycle. They also assume that the thresholds stay steady between the decisions that use them. The stimulus drives every input on the falling edge. It changes `hi_lim`, `lo_lim` and `enable` only while reset is held or well away from a decision point. The counter properties therefore see each event exactly once, and step moves come only from flag decisions.

// File: rtl/apc_pkg.sv
package apc_pkg;
  typedef enum logic [1:0] {
    ADJ_HOLD    = 2'd0,
    ADJ_SHORTER = 2'd1,
    ADJ_LONGER  = 2'd2
  } adj_e;
endpackage

// File: rtl/apc_event_ctr.sv
module apc_event_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             inc,
  input  logic             dec,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIDV = {1'b1, {(CNT_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= MIDV;
    end else if (reload) begin
      cnt_o <= MIDV;
    end else if (en) begin
      if (inc && !dec && cnt_o != MAXV)
        cnt_o <= cnt_o + 1'b1;
      else if (dec && !inc && cnt_o != '0)
        cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/apc_interval_timer.sv
module apc_interval_timer #(
  parameter int MIN_LOG = 4,
  parameter int STEPS   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(STEPS)-1:0] step,
  output logic                     fire,
  output logic                     flag
);
  localparam int TMR_W = MIN_LOG + STEPS - 1;

  logic [TMR_W-1:0] tmr;
  logic [TMR_W-1:0] last_tick [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_len
    assign last_tick[g] = TMR_W'((64'd1 << (MIN_LOG + g)) - 64'd1);
  end

  assign fire = (tmr == last_tick[step]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr  <= '0;
      flag <= 1'b0;
    end else begin
      tmr  <= fire ? '0 : tmr + 1'b1;
      flag <= fire;
    end
  end
endmodule

// File: rtl/apc_step_ctrl.sv
module apc_step_ctrl
  import apc_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LIM_W    = 9,
  parameter int STEPS    = 8,
  parameter int RST_STEP = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     fire,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [LIM_W-1:0]         hi_lim,
  input  logic [LIM_W-1:0]         lo_lim,
  output logic [$clog2(STEPS)-1:0] step_o,
  output logic                     reload_o
);
  localparam int TH_W = CNT_W + 1;
  localparam int SH   = TH_W - LIM_W;
  localparam int SW   = $clog2(STEPS);
  localparam logic [SW-1:0] TOP_STEP = SW'(STEPS - 1);

  logic [TH_W-1:0] hi_th, lo_th, cnt_x;
  logic            over, under;
  adj_e            adj;

  assign hi_th = {hi_lim, {SH{1'b0}}};
  assign lo_th = {lo_lim, {SH{1'b0}}};
  assign cnt_x = {1'b0, cnt};
  assign over  = cnt_x > hi_th;
  assign under = cnt_x < lo_th;

  always_comb begin
    adj = ADJ_HOLD;
    if (en && fire) begin
      if (over) begin
        if (step_o != '0) adj = ADJ_SHORTER;
      end else if (under) begin
        if (step_o != TOP_STEP) adj = ADJ_LONGER;
      end
    end
  end

  assign reload_o = (adj != ADJ_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_o <= SW'(RST_STEP);
    end else begin
      case (adj)
        ADJ_SHORTER: step_o <= step_o - 1'b1;
        ADJ_LONGER:  step_o <= step_o + 1'b1;
        default:     step_o <= step_o;
      endcase
    end
  end
endmodule

// File: rtl/page_close_adapt.sv
module page_close_adapt #(
  parameter int CNT_W    = 12,
  parameter int LIM_W    = 9,
  parameter int STAT_W   = 8,
  parameter int STEPS    = 8,
  parameter int MIN_LOG  = 4,
  parameter int RST_STEP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [LIM_W-1:0]  hi_lim,
  input  logic [LIM_W-1:0]  lo_lim,
  input  logic              mistake,
  input  logic              hit,
  output logic              close_flag,
  output logic [STAT_W-1:0] cnt_msb
);
  localparam int SW = $clog2(STEPS);

  logic [CNT_W-1:0] cnt_q;
  logic [SW-1:0]    step_q;
  logic             fire;
  logic             reload;

  apc_interval_timer #(.MIN_LOG(MIN_LOG), .STEPS(STEPS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step_q),
    .fire  (fire),
    .flag  (close_flag)
  );

  apc_step_ctrl #(
    .CNT_W(CNT_W), .LIM_W(LIM_W), .STEPS(STEPS), .RST_STEP(RST_STEP)
  ) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .fire     (fire),
    .cnt      (cnt_q),
    .hi_lim   (hi_lim),
    .lo_lim   (lo_lim),
    .step_o   (step_q),
    .reload_o (reload)
  );

  apc_event_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (enable),
    .inc    (mistake),
    .dec    (hit),
    .reload (reload),
    .cnt_o  (cnt_q)
  );

  assign cnt_msb = cnt_q[CNT_W-1 -: STAT_W];
endmodule

// File: rtl/page_close_adapt_chk.sv
module page_close_adapt_chk #(
  parameter int CNT_W = 12,
  parameter int STEPS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     enable,
  input logic                     mistake,
  input logic                     hit,
  input logic                     close_flag,
  input logic                     fire,
  input logic [$clog2(STEPS)-1:0] step_q,
  input logic [CNT_W-1:0]         cnt_q
);
  localparam logic [CNT_W-1:0] TOPV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIDV = {1'b1, {(CNT_W-1){1'b0}}};

  AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    close_flag |=> !close_flag); // R2

  AST_STEP_ONLY_AT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(step_q)); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (step_q == $past(step_q) || step_q == $past(step_q) + 1'b1 ||
              step_q + 1'b1 == $past(step_q))); // R6

  AST_RELOAD_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_q) |-> cnt_q == MIDV); // R6

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(cnt_q) && $stable(step_q))); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !fire && cnt_q == TOPV && mistake && !hit) |=> cnt_q == TOPV); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !fire && cnt_q == '0 && hit && !mistake) |=> cnt_q == '0); // R4

  AST_BOTH_EVENTS_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !fire && mistake && hit) |=> $stable(cnt_q)); // R3
endmodule

bind page_close_adapt page_close_adapt_chk #(.CNT_W(CNT_W), .STEPS(STEPS)) u_chk (.*);

// File: tb/page_close_adapt_bench.sv
module page_close_adapt_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [8:0] hi_lim = '0;
  logic [8:0] lo_lim = '0;
  logic       mistake = 1'b0;
  logic       hit = 1'b0;
  logic       close_flag;
  logic [7:0] cnt_msb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  page_close_adapt u_page_close_adapt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hi_lim(hi_lim), .lo_lim(lo_lim),
    .mistake(mistake), .hit(hit), .close_flag(close_flag), .cnt_msb(cnt_msb)
  );

  // {mistake-only cycles, hit-only cycles, both-high cycles, expected cnt_msb}
  localparam int VEC [6][4] = '{
    '{16, 0,  0, 'h81},
    '{ 0, 32, 0, 'h7F},
    '{ 0, 0, 20, 'h7F},
    '{ 5, 3,  4, 'h7F},
    '{14, 0,  0, 'h80},
    '{ 3, 1,  0, 'h80}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic en, input logic [8:0] hi, input logic [8:0] lo);
    @(negedge clk);
    rst_n = 1'b0; enable = en; hi_lim = hi; lo_lim = lo; mistake = 1'b0; hit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulses(input int m, input int h, input int b);
    for (int i = 0; i < m; i++) begin mistake = 1'b1; hit = 1'b0; @(negedge clk); end
    for (int i = 0; i < h; i++) begin mistake = 1'b0; hit = 1'b1; @(negedge clk); end
    for (int i = 0; i < b; i++) begin mistake = 1'b1; hit = 1'b1; @(negedge clk); end
    mistake = 1'b0; hit = 1'b0;
  endtask

  task automatic wait_flag();
    do @(negedge clk); while (!close_flag);
  endtask

  task automatic next_period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!close_flag && n < 5000);
  endtask

  initial begin
    int p;
    int first;

    // R1: reset state and first flag position
    do_reset(1'b1, 9'h1FF, 9'h000);
    chk("R1 flag low at reset", close_flag, 0);
    chk("R1 cnt_msb at reset", cnt_msb, 'h80);
    first = 0;
    for (int k = 1; k <= 300 && first == 0; k++) begin
      @(negedge clk);
      if (close_flag) first = k;
    end
    chk("R1 first flag clock", first, 128);
    @(negedge clk);
    chk("R2 flag single cycle", close_flag, 0);
    first = 1;
    p = 0;
    do begin @(negedge clk); first++; end while (!close_flag && first < 5000);
    chk("R2 period at step 3", first, 128);

    // R3 and R11: event vectors with a wide band, so no step move
    do_reset(1'b1, 9'h1FF, 9'h000);
    @(negedge clk);
    for (int v = 0; v < 6; v++) begin
      pulses(VEC[v][0], VEC[v][1], VEC[v][2]);
      chk($sformatf("R3 R11 vector %0d", v), cnt_msb, VEC[v][3]);
    end

    // R4: saturation at the top, then at the bottom
    pulses(2100, 0, 0);
    chk("R4 top saturated", cnt_msb, 'hFF);
    pulses(0, 15, 0);
    chk("R4 top minus 15", cnt_msb, 'hFF);
    pulses(0, 1, 0);
    chk("R4 top minus 16", cnt_msb, 'hFE);
    pulses(0, 4200, 0);
    chk("R4 bottom saturated", cnt_msb, 'h00);
    pulses(15, 0, 0);
    chk("R4 bottom plus 15", cnt_msb, 'h00);
    pulses(1, 0, 0);
    chk("R4 bottom plus 16", cnt_msb, 'h01);

    // R5 and R8: counter 2048 over threshold 2032, so the interval shrinks to the floor
    do_reset(1'b1, 9'h07F, 9'h000);
    wait_flag();
    next_period(p); chk("R5 period after 1st move", p, 64);
    chk("R5 counter reloaded", cnt_msb, 'h80);
    next_period(p); chk("R5 period after 2nd move", p, 32);
    next_period(p); chk("R5 period after 3rd move", p, 16);
    next_period(p); chk("R8 period held at floor", p, 16);
    pulses(16, 0, 0);
    chk("R8 counter kept at floor", cnt_msb, 'h81);

    // R6 and R8: counter 2048 under threshold 2064, so the interval grows to the ceiling
    do_reset(1'b1, 9'h1FF, 9'h081);
    wait_flag();
    next_period(p); chk("R6 period 256", p, 256);
    next_period(p); chk("R6 period 512", p, 512);
    next_period(p); chk("R6 period 1024", p, 1024);
    next_period(p); chk("R6 period 2048", p, 2048);
    next_period(p); chk("R8 period held at ceiling", p, 2048);
    pulses(0, 16, 0);
    chk("R8 counter kept at ceiling", cnt_msb, 'h7F);

    // R7: both thresholds crossed, the upper wins
    do_reset(1'b1, 9'h07F, 9'h081);
    wait_flag();
    next_period(p); chk("R7 upper comparison wins", p, 64);

    // R10: counter equal to both thresholds, no move
    do_reset(1'b1, 9'h080, 9'h080);
    wait_flag();
    next_period(p); chk("R10 equal holds 1", p, 128);
    next_period(p); chk("R10 equal holds 2", p, 128);

    // R9: disabled, no adaptation and no counting
    do_reset(1'b0, 9'h07F, 9'h000);
    wait_flag();
    next_period(p); chk("R9 period unchanged 1", p, 128);
    next_period(p); chk("R9 period unchanged 2", p, 128);
    pulses(16, 0, 0);
    chk("R9 counter frozen", cnt_msb, 'h80);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule